// File: doc/BRIEF.md
# Seven-to-one LVDS pixel serializer with selectable lane mapping

The block accepts one parallel pixel per pixel clock (8-bit red, green and blue plus horizontal sync, vertical sync and data enable) and spreads it over up to four single-ended data lanes and one clock lane. Each lane sends seven bit slots per pixel period, clocked by a bit clock that runs at seven times the pixel rate and is phase-aligned to it. Differential buffers, generation of the fast clock and panel timing live outside this block.

Three colour-to-slot arrangements are available at run time: an 18-bit arrangement on three lanes, a 24-bit arrangement whose fourth lane carries the two least significant bits of each colour, and a 24-bit arrangement whose fourth lane carries the two most significant bits. A mirror control reverses the slot order on every data lane. The pixel, the mapping mode and the mirror setting are captured together on each pixel clock edge, mapped into seven-bit lane words, and reloaded into per-lane shift registers when the bit-clock slot counter wraps.

Top module: `lvds_ser_tx`

## Requirements
- R1: Every data lane sends seven slots per pixel period, slot 0 first; a pixel captured on pixel clock edge k is sent in the period that begins at edge k+1, with slot 0 starting at that edge.
- R2: The clock lane is high in slots 0, 1, 5 and 6 and low in slots 2, 3 and 4 of every pixel period, whatever the mode or mirror setting.
- R3: Mode 0 (18-bit): lane 0 sends G[2],R[7],R[6],R[5],R[4],R[3],R[2] in slots 0 to 6; lane 1 sends B[3],B[2],G[7],G[6],G[5],G[4],G[3]; lane 2 sends DE,VSYNC,HSYNC,B[7],B[6],B[5],B[4]; lane 3 stays low.
- R4: Mode 1 (24-bit, low bits on lane 3): lanes 0 to 2 are as in R3, and lane 3 sends 0,B[1],B[0],G[1],G[0],R[1],R[0] in slots 0 to 6.
- R5: Mode 2 (24-bit, high bits on lane 3): lane 0 sends G[0],R[5],R[4],R[3],R[2],R[1],R[0]; lane 1 sends B[1],B[0],G[5],G[4],G[3],G[2],G[1]; lane 2 sends DE,VSYNC,HSYNC,B[5],B[4],B[3],B[2]; lane 3 sends 0,B[7],B[6],G[7],G[6],R[7],R[6].
- R6: Mode value 3 is treated exactly as mode 0.
- R7: With mirror_en high, every data lane sends the slot-6 bit of its normal word first and the slot-0 bit last; the clock lane is unchanged.
- R8: Mode and mirror are sampled only on the pixel clock edge together with the pixel; changing them between edges alters neither the word in flight nor a later word unless the change is present at an edge.
- R9: While rst_n is low all data lanes and the clock lane are 0; the first bit clock edge after release starts slot 0, and the first pixel period after reset sends all-zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Slot clock, seven times the pixel rate, rising edges aligned with pix_clk |
| pix_clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| red | input | 8 | Red channel |
| green | input | 8 | Green channel |
| blue | input | 8 | Blue channel |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data enable |
| map_mode | input | 2 | Lane mapping select, 0 to 3 |
| mirror_en | input | 1 | Reverse slot order on data lanes |
| lane_data | output | 4 | Serial data lanes, bit i is lane i |
| lane_clk | output | 1 | Serial clock lane |

## Verification
The bench rebuilds each lane's seven-bit word from samples taken mid-slot and compares it with a mapping it computes from concatenations of the pixel fields, for all four mode values with and without mirroring, so a swapped slot, a wrong colour bit range or a reversed mirror shows as a lane mismatch. The first pixel period after reset must be all zeros with the clock pattern already in phase; a counter that started at the wrong slot or a reload taken from the live input would shift or corrupt it. A mode and mirror change made mid-period and withdrawn before the next edge must leave both the in-flight word and the following word untouched, which catches mapping done combinationally in the fast domain.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

  localparam int LVDS_SLOTS     = 7;
  localparam int LVDS_LANES     = 4;
  localparam int CHAN_W         = 8;
  localparam int SUB_W          = 6;
  localparam int SLOT_W         = $clog2(LVDS_SLOTS);
  localparam int CLK_HEAD       = 2;
  localparam int CLK_TAIL_START = 5;

  typedef enum logic [1:0] {
    MAP_18B       = 2'd0,
    MAP_24B_SPLIT = 2'd1,
    MAP_24B_HIGH  = 2'd2,
    MAP_RSVD      = 2'd3
  } map_mode_e;

  typedef struct packed {
    logic [CHAN_W-1:0] r;
    logic [CHAN_W-1:0] g;
    logic [CHAN_W-1:0] b;
    logic              hs;
    logic              vs;
    logic              de;
  } pixel_t;

  typedef logic [LVDS_SLOTS-1:0]  slot_word_t;
  typedef slot_word_t [LVDS_LANES-1:0] lane_bundle_t;

  // Six-bit colour field: low bits when low_sel, otherwise the top six.
  function automatic logic [SUB_W-1:0] pick6(logic [CHAN_W-1:0] c, logic low_sel);
    return low_sel ? c[SUB_W-1:0] : c[CHAN_W-1:CHAN_W-SUB_W];
  endfunction

  // Two-bit extension field: top bits when high_sel, otherwise the bottom two.
  function automatic logic [1:0] pick2(logic [CHAN_W-1:0] c, logic high_sel);
    return high_sel ? c[CHAN_W-1:CHAN_W-2] : c[1:0];
  endfunction

  function automatic slot_word_t reverse_slots(slot_word_t w);
    slot_word_t o;
    for (int k = 0; k < LVDS_SLOTS; k++) o[k] = w[LVDS_SLOTS-1-k];
    return o;
  endfunction

  function automatic logic is_wide(map_mode_e m);
    return (m == MAP_24B_SPLIT) || (m == MAP_24B_HIGH);
  endfunction

  // Maps one pixel to per-lane seven-slot words (bit k = slot k).
  function automatic lane_bundle_t map_pixel(pixel_t px, map_mode_e m, logic mirror);
    lane_bundle_t     lw;
    logic             hi;
    logic [SUB_W-1:0] r6, g6, b6;
    logic [1:0]       pr, pg, pb;
    hi = (m == MAP_24B_HIGH);
    r6 = pick6(px.r, hi);
    g6 = pick6(px.g, hi);
    b6 = pick6(px.b, hi);
    pr = pick2(px.r, hi);
    pg = pick2(px.g, hi);
    pb = pick2(px.b, hi);
    lw = '0;
    lw[0][0] = g6[0];
    for (int k = 1; k < LVDS_SLOTS; k++) lw[0][k] = r6[LVDS_SLOTS-1-k];
    lw[1][0] = b6[1];
    lw[1][1] = b6[0];
    for (int k = 2; k < LVDS_SLOTS; k++) lw[1][k] = g6[LVDS_SLOTS-k];
    lw[2][0] = px.de;
    lw[2][1] = px.vs;
    lw[2][2] = px.hs;
    for (int k = 3; k < LVDS_SLOTS; k++) lw[2][k] = b6[LVDS_SLOTS+1-k];
    if (is_wide(m)) begin
      lw[3][0] = 1'b0;
      lw[3][1] = pb[1];
      lw[3][2] = pb[0];
      lw[3][3] = pg[1];
      lw[3][4] = pg[0];
      lw[3][5] = pr[1];
      lw[3][6] = pr[0];
    end
    if (mirror) begin
      for (int l = 0; l < LVDS_LANES; l++) lw[l] = reverse_slots(lw[l]);
    end
    return lw;
  endfunction

  function automatic logic clk_level(logic [SLOT_W-1:0] slot);
    return (int'(slot) < CLK_HEAD) || (int'(slot) >= CLK_TAIL_START);
  endfunction

endpackage

// File: rtl/lvds_slot_mapper.sv
module lvds_slot_mapper
  import lvds_ser_pkg::*;
(
  input  pixel_t       px,
  input  map_mode_e    mode,
  input  logic         mirror,
  output lane_bundle_t lanes,
  output logic         narrow
);
  assign lanes  = map_pixel(px, mode, mirror);
  assign narrow = !is_wide(mode);
endmodule

// File: rtl/lvds_pix_stage.sv
module lvds_pix_stage
  import lvds_ser_pkg::*;
(
  input  logic         pix_clk,
  input  logic         rst_n,
  input  lane_bundle_t lanes_d,
  input  logic         narrow_d,
  input  logic         mirror_d,
  output lane_bundle_t lanes_q,
  output logic         narrow_q,
  output logic         mirror_q
);
  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      lanes_q  <= '0;
      narrow_q <= 1'b1;
      mirror_q <= 1'b0;
    end else begin
      lanes_q  <= lanes_d;
      narrow_q <= narrow_d;
      mirror_q <= mirror_d;
    end
  end
endmodule

// File: rtl/lvds_slot_timer.sv
module lvds_slot_timer
  import lvds_ser_pkg::*;
(
  input  logic              bit_clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_cnt,
  output logic              load_evt,
  output logic              lane_clk
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LVDS_SLOTS-1);

  logic [SLOT_W-1:0] slot_nxt;

  assign load_evt = (slot_cnt == LAST_SLOT);
  assign slot_nxt = load_evt ? '0 : slot_cnt + 1'b1;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_cnt <= LAST_SLOT;
      lane_clk <= 1'b0;
    end else begin
      slot_cnt <= slot_nxt;
      lane_clk <= clk_level(slot_nxt);
    end
  end
endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter #(
  parameter int SLOTS = 7
) (
  input  logic             bit_clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SLOTS-1:0] word,
  output logic             bit_o
);
  logic [SLOTS-1:0] shreg;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n)    shreg <= '0;
    else if (load) shreg <= word;
    else           shreg <= {1'b0, shreg[SLOTS-1:1]};
  end

  assign bit_o = shreg[0];
endmodule

// File: rtl/lvds_ser_tx.sv
module lvds_ser_tx
  import lvds_ser_pkg::*;
#(
  parameter int NUM_LANES = LVDS_LANES
) (
  input  logic                 bit_clk,
  input  logic                 pix_clk,
  input  logic                 rst_n,
  input  logic [CHAN_W-1:0]    red,
  input  logic [CHAN_W-1:0]    green,
  input  logic [CHAN_W-1:0]    blue,
  input  logic                 hsync,
  input  logic                 vsync,
  input  logic                 de,
  input  logic [1:0]           map_mode,
  input  logic                 mirror_en,
  output logic [NUM_LANES-1:0] lane_data,
  output logic                 lane_clk
);
  pixel_t            px_in;
  map_mode_e         mode_in;
  lane_bundle_t      lanes_d;
  lane_bundle_t      lanes_q;
  logic              narrow_d;
  logic              narrow_q;
  logic              mirror_q;
  logic [SLOT_W-1:0] slot_cnt;
  logic              load_evt;

  assign px_in   = '{r: red, g: green, b: blue, hs: hsync, vs: vsync, de: de};
  assign mode_in = map_mode_e'(map_mode);

  lvds_slot_mapper u_map (
    .px     (px_in),
    .mode   (mode_in),
    .mirror (mirror_en),
    .lanes  (lanes_d),
    .narrow (narrow_d)
  );

  lvds_pix_stage u_pix (
    .pix_clk  (pix_clk),
    .rst_n    (rst_n),
    .lanes_d  (lanes_d),
    .narrow_d (narrow_d),
    .mirror_d (mirror_en),
    .lanes_q  (lanes_q),
    .narrow_q (narrow_q),
    .mirror_q (mirror_q)
  );

  lvds_slot_timer u_tmr (
    .bit_clk  (bit_clk),
    .rst_n    (rst_n),
    .slot_cnt (slot_cnt),
    .load_evt (load_evt),
    .lane_clk (lane_clk)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    lvds_lane_shifter #(.SLOTS(LVDS_SLOTS)) u_sh (
      .bit_clk (bit_clk),
      .rst_n   (rst_n),
      .load    (load_evt),
      .word    (lanes_q[l]),
      .bit_o   (lane_data[l])
    );
  end
endmodule

// File: rtl/lvds_ser_tx_chk.sv
module lvds_ser_tx_chk
  import lvds_ser_pkg::*;
#(
  parameter int NUM_LANES = LVDS_LANES
) (
  input logic                 bit_clk,
  input logic                 rst_n,
  input logic [SLOT_W-1:0]    slot_cnt,
  input logic                 load_evt,
  input logic                 lane_clk,
  input logic [NUM_LANES-1:0] lane_data,
  input logic                 narrow_q,
  input logic                 mirror_q
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LVDS_SLOTS-1);

  AST_SLOT_ADVANCE: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (slot_cnt != LAST_SLOT) |=> (slot_cnt == SLOT_W'($past(slot_cnt) + 1'b1))); // R1

  AST_RELOAD_START: assert property (@(posedge bit_clk) disable iff (!rst_n)
    load_evt |=> (slot_cnt == '0) && lane_clk); // R2

  AST_CLK_LOW_MID: assert property (@(posedge bit_clk) disable iff (!rst_n)
    ((slot_cnt >= SLOT_W'(CLK_HEAD)) && (slot_cnt < SLOT_W'(CLK_TAIL_START))) |-> !lane_clk); // R2

  if (NUM_LANES > 3) begin : g_l3
    AST_NARROW_L3_LOW: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (load_evt && narrow_q) |=> !lane_data[3]); // R3

    AST_CTL3_SLOT0: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (load_evt && !mirror_q) |=> !lane_data[3]); // R4
  end
endmodule

bind lvds_ser_tx lvds_ser_tx_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .bit_clk   (bit_clk),
  .rst_n     (rst_n),
  .slot_cnt  (slot_cnt),
  .load_evt  (load_evt),
  .lane_clk  (lane_clk),
  .lane_data (lane_data),
  .narrow_q  (narrow_q),
  .mirror_q  (mirror_q)
);

// File: tb/lvds_ser_tx_tb.sv
module lvds_ser_tx_tb;
  // vector layout: mode[29:28] mirror[27] de[26] vs[25] hs[24] b[23:16] g[15:8] r[7:0]
  localparam int NV = 12;
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h3C, 8'hF0},
    {2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0F, 8'hC3, 8'h81},
    {2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 8'h96, 8'h0F},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 8'hFF},
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 8'hC6, 8'h39, 8'hE7},
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 8'h80, 8'h7E},
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h12, 8'h34, 8'h56},
    {2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h9B, 8'hD2, 8'h4F},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3E, 8'hC1, 8'hA9},
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h3C, 8'hF0},
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 8'h77, 8'h88, 8'h99},
    {2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF}
  };
  localparam logic [6:0] CLK_PAT = 7'b1100011;

  logic       bit_clk = 1'b0;
  logic       pix_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic [7:0] red, green, blue;
  logic       hsync, vsync, de;
  logic [1:0] map_mode;
  logic       mirror_en;
  logic [3:0] lane_data;
  logic       lane_clk;
  int ph = 0;
  int n_chk = 0;
  int n_fail = 0;

  lvds_ser_tx u_dut (
    .bit_clk(bit_clk), .pix_clk(pix_clk), .rst_n(rst_n),
    .red(red), .green(green), .blue(blue),
    .hsync(hsync), .vsync(vsync), .de(de),
    .map_mode(map_mode), .mirror_en(mirror_en),
    .lane_data(lane_data), .lane_clk(lane_clk)
  );

  // 125 MHz bit clock; pixel clock rises on every seventh bit clock edge.
  initial forever begin
    #4;
    bit_clk = 1'b1;
    if (ph == 0) pix_clk = 1'b1;
    else if (ph == 4) pix_clk = 1'b0;
    ph = (ph + 1) % 7;
    #4;
    bit_clk = 1'b0;
  end

  function automatic logic [3:0][6:0] exp_words(logic [29:0] v);
    logic [3:0][6:0] e;
    logic [7:0] r, g, b;
    logic [5:0] rr, gg, bb;
    logic [1:0] md;
    md = v[29:28];
    r = v[7:0]; g = v[15:8]; b = v[23:16];
    rr = (md == 2'd2) ? r[5:0] : r[7:2];
    gg = (md == 2'd2) ? g[5:0] : g[7:2];
    bb = (md == 2'd2) ? b[5:0] : b[7:2];
    // words written slot 6 down to slot 0
    e[0] = {rr[0], rr[1], rr[2], rr[3], rr[4], rr[5], gg[0]};
    e[1] = {gg[1], gg[2], gg[3], gg[4], gg[5], bb[0], bb[1]};
    e[2] = {bb[2], bb[3], bb[4], bb[5], v[24], v[25], v[26]};
    case (md)
      2'd1:    e[3] = {r[0], r[1], g[0], g[1], b[0], b[1], 1'b0};
      2'd2:    e[3] = {r[6], r[7], g[6], g[7], b[6], b[7], 1'b0};
      default: e[3] = 7'd0;
    endcase
    if (v[27]) begin
      for (int l = 0; l < 4; l++) begin
        logic [6:0] t;
        t = e[l];
        for (int s = 0; s < 7; s++) e[l][s] = t[6-s];
      end
    end
    return e;
  endfunction

  function automatic string tag_of(logic [29:0] v);
    if (v[27]) return "R7";
    case (v[29:28])
      2'd0:    return "R3";
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(logic [29:0] v);
    map_mode = v[29:28]; mirror_en = v[27];
    de = v[26]; vsync = v[25]; hsync = v[24];
    blue = v[23:16]; green = v[15:8]; red = v[7:0];
  endtask

  task automatic collect(output logic [3:0][6:0] w, output logic [6:0] cw);
    @(posedge pix_clk);
    for (int s = 0; s < 7; s++) begin
      @(negedge bit_clk);
      for (int l = 0; l < 4; l++) w[l][s] = lane_data[l];
      cw[s] = lane_clk;
    end
  endtask

  task automatic verify(string tag, logic [3:0][6:0] e, logic [3:0][6:0] w, logic [6:0] cw);
    for (int l = 0; l < 4; l++) begin
      n_chk++;
      if (w[l] !== e[l]) begin
        n_fail++;
        $display("FAIL R1 %s lane %0d: actual %b expected %b", tag, l, w[l], e[l]);
      end
    end
    n_chk++;
    if (cw !== CLK_PAT) begin
      n_fail++;
      $display("FAIL R2 (%s) clock lane: actual %b expected %b", tag, cw, CLK_PAT);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [3:0][6:0] w;
    logic [6:0]      cw;
    logic [29:0]     prev;
    logic [29:0]     pk;
    apply(VEC[0]);
    repeat (3) @(negedge bit_clk);
    n_chk++;
    if (lane_data !== 4'd0 || lane_clk !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 in reset: actual data %b clk %b expected 0000 0", lane_data, lane_clk);
    end
    do @(negedge bit_clk); while (ph != 0);
    rst_n = 1'b1;
    // R9: first period after reset carries zeros, clock pattern from slot 0
    collect(w, cw);
    verify("R9", '0, w, cw);
    prev = VEC[0];
    for (int i = 1; i < NV; i++) begin
      apply(VEC[i]);
      collect(w, cw);
      verify(tag_of(prev), exp_words(prev), w, cw);
      prev = VEC[i];
    end
    // R8: mode/mirror glitch between edges must not reach the lanes
    pk = {2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hC3, 8'h5A, 8'h96};
    apply(pk);
    collect(w, cw);
    verify(tag_of(prev), exp_words(prev), w, cw);
    @(posedge pix_clk);
    for (int s = 0; s < 7; s++) begin
      @(negedge bit_clk);
      for (int l = 0; l < 4; l++) w[l][s] = lane_data[l];
      cw[s] = lane_clk;
      if (s == 2) begin map_mode = 2'd2; mirror_en = 1'b1; end
    end
    map_mode = 2'd1; mirror_en = 1'b0;
    verify("R8 in-flight", exp_words(pk), w, cw);
    collect(w, cw);
    verify("R8 next", exp_words(pk), w, cw);
    collect(w, cw);
    verify("R8 after", exp_words(pk), w, cw);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule